// File: doc/BRIEF.md
# Mailbox-Triggered Dual-Port RAM Burst Read Controller

This controller sits between the read port of a dual-port static RAM and the programmable FIFO interface of a USB device controller. When the data producer finishes filling one of two ping-pong buffers, it writes a code into the RAM mailbox, and the RAM pulls an active-low interrupt line. The controller then raises an interrupt request to the USB controller. It waits for a ready reply, reads the mailbox byte from the RAM, and decodes which buffer holds the fresh data. It then opens the RAM read port for one bulk burst.

During the burst the USB controller paces the transfer. It drives only the low nine word-address bits and holds each address for about four of its clock cycles, so the RAM access time is met. The controller keeps the upper address bits itself. It loads them from the chosen buffer's base and steps them by one each time the USB address wraps. It detects a wrap as a falling edge of USB address bit 8, found by sampling that bit and comparing it with its value one cycle earlier. Read data goes from the RAM straight to the USB side, so no data stream passes through this block and no back-pressure applies. The pace of the burst is set only by how fast the USB master advances its address. After the fixed number of words, the controller releases the RAM and withdraws its request.

Top module: `usb_rd_bridge`

## Requirements
- R1: Out of reset, and while idle with `mbox_irq_n` high, `usb_irq` is 0 and `ram_ce_n`/`ram_oe_n` are 1. A low `mbox_irq_n` while idle makes `usb_irq` 1 from the next cycle on.
- R2: The RAM stays deselected while `usb_irq` is up and `usb_ready` is low. In the cycle after `usb_ready` is seen high, `ram_ce_n` and `ram_oe_n` are 0 and `ram_addr` equals the mailbox address (default 0x3FFF).
- R3: The mailbox byte is sampled `MBOX_CYC` cycles after the mailbox address appears (default 2). Byte 0x00 starts a burst with `ram_addr[13:9]` = 2, the word base 1024. Byte 0xFF starts it with `ram_addr[13:9]` = 10, the word base 5120.
- R4: Any other mailbox byte is ignored. In the cycle after sampling, `usb_irq` is 0 and the RAM is deselected, and no burst follows.
- R5: During a burst, `ram_addr` is registered: each cycle it becomes {upper bits, `usb_addr`} using the `usb_addr` value sampled at that clock edge.
- R6: During a burst, a sample of `usb_addr[8]` at 0 that follows a sample at 1 raises the upper bits by one in that same update. A 0-to-1 change leaves them unchanged.
- R7: From the mailbox read to the end of the burst, `ram_ce_n` and `ram_oe_n` stay 0. `ram_wr_n` is 1 at all times, so the RAM is always in read mode.
- R8: On the `XFER_WORDS/512`-th falling edge of `usb_addr[8]` (8 with the default of 4096 words), the burst ends. From the next cycle on, `usb_irq` is 0 and the RAM is deselected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mbox_irq_n | input | 1 | Active-low mailbox interrupt from the RAM |
| usb_irq | output | 1 | Interrupt request to the USB controller, held through the transfer |
| usb_ready | input | 1 | USB controller ready to receive |
| usb_addr | input | 9 | Low word-address bits driven by the USB controller |
| mbox_rdata | input | 8 | Low byte of the RAM read data bus |
| ram_addr | output | 14 | Registered RAM word address |
| ram_ce_n | output | 1 | RAM chip enable, active low |
| ram_oe_n | output | 1 | RAM output enable, active low |
| ram_wr_n | output | 1 | RAM write strobe, held high (read mode) |

## Verification
The bench builds the block with its default parameters: 14 address bits, 9 USB bits, 4096-word transfers and a two-cycle mailbox wait. Full-length bursts from both buffers therefore run through all eight upper-address steps and end at the real buffer boundary. A behavioural model tracks the phase, upper bits and expected address on every clock. Directed stimuli add a delayed ready reply, an illegal mailbox code, irregular USB hold times, and the 0-to-1 edge of bit 8 in the middle of each block.

// File: rtl/usbrd_pkg.sv
package usbrd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_REQ   = 2'd1,
    ST_MBOX  = 2'd2,
    ST_BURST = 2'd3
  } rd_state_t;
endpackage

// File: rtl/usbrd_fall_detect.sv
module usbrd_fall_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic sig,
  output logic fall
);
  logic sig_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sig_q <= 1'b0;
    else        sig_q <= sig;
  end

  assign fall = sig_q & ~sig;

  // R6: two falls in a row are impossible, since the history bit drops with the first
  assert_fall_isolated_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> !fall);
endmodule

// File: rtl/usbrd_blk_addr.sv
module usbrd_blk_addr #(
  parameter int HI_W      = 5,
  parameter int XFER_BLKS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [HI_W-1:0] load_hi,
  input  logic            step,
  output logic [HI_W-1:0] hi_next,
  output logic            last_blk
);
  localparam int CNT_W = $clog2(XFER_BLKS + 1);

  logic [HI_W-1:0]  hi_q;
  logic [CNT_W-1:0] blk_q;

  assign hi_next  = hi_q + HI_W'(step);
  assign last_blk = step && (blk_q == CNT_W'(XFER_BLKS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q  <= '0;
      blk_q <= '0;
    end else if (load) begin
      hi_q  <= load_hi;
      blk_q <= '0;
    end else if (step) begin
      hi_q  <= hi_next;
      blk_q <= last_blk ? '0 : blk_q + CNT_W'(1);
    end
  end

  // R8: the block counter never runs past the transfer length
  assert_blk_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    blk_q < CNT_W'(XFER_BLKS));
endmodule

// File: rtl/usbrd_seq.sv
module usbrd_seq
  import usbrd_pkg::*;
#(
  parameter int MBOX_W   = 8,
  parameter int HI_W     = 5,
  parameter int MBOX_CYC = 2,
  parameter logic [HI_W-1:0] BUF0_HI = 5'd2,
  parameter logic [HI_W-1:0] BUF1_HI = 5'd10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mbox_irq_n,
  input  logic              usb_ready,
  input  logic [MBOX_W-1:0] mbox_byte,
  input  logic              last_blk,
  output rd_state_t         state,
  output logic              mbox_enter,
  output logic              load,
  output logic [HI_W-1:0]   load_hi
);
  localparam int MC_W = (MBOX_CYC > 1) ? $clog2(MBOX_CYC) : 1;

  rd_state_t       nxt;
  logic [MC_W-1:0] cnt_q;
  logic            code_lo, code_hi, code_ok, mbox_done;

  assign code_lo    = (mbox_byte == '0);
  assign code_hi    = (mbox_byte == '1);
  assign code_ok    = code_lo | code_hi;
  assign mbox_done  = (state == ST_MBOX) && (cnt_q == MC_W'(MBOX_CYC - 1));
  assign mbox_enter = (state == ST_REQ) && usb_ready;
  assign load       = mbox_done && code_ok;
  assign load_hi    = code_hi ? BUF1_HI : BUF0_HI;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE:  if (!mbox_irq_n) nxt = ST_REQ;
      ST_REQ:   if (usb_ready)   nxt = ST_MBOX;
      ST_MBOX:  if (mbox_done)   nxt = code_ok ? ST_BURST : ST_IDLE;
      ST_BURST: if (last_blk)    nxt = ST_IDLE;
      default:                   nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      state <= nxt;
      if (state == ST_MBOX && !mbox_done) cnt_q <= cnt_q + MC_W'(1);
      else                                cnt_q <= '0;
    end
  end

  // R2: without a ready reply the request phase is held
  assert_wait_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_REQ && !usb_ready) |=> (state == ST_REQ));
  // R4: an illegal mailbox code sends the sequencer straight back to idle
  assert_bad_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mbox_done && !code_ok) |=> (state == ST_IDLE));
endmodule

// File: rtl/usb_rd_bridge.sv
module usb_rd_bridge
  import usbrd_pkg::*;
#(
  parameter int ADDR_W     = 14,
  parameter int LOW_W      = 9,
  parameter int MBOX_W     = 8,
  parameter int BUF0_BASE  = 1024,
  parameter int BUF1_BASE  = 5120,
  parameter int XFER_WORDS = 4096,
  parameter int MBOX_ADDR  = 16383,
  parameter int MBOX_CYC   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mbox_irq_n,
  output logic              usb_irq,
  input  logic              usb_ready,
  input  logic [LOW_W-1:0]  usb_addr,
  input  logic [MBOX_W-1:0] mbox_rdata,
  output logic [ADDR_W-1:0] ram_addr,
  output logic              ram_ce_n,
  output logic              ram_oe_n,
  output logic              ram_wr_n
);
  localparam int HI_W      = ADDR_W - LOW_W;
  localparam int BLK_WORDS = 1 << LOW_W;
  localparam int XFER_BLKS = XFER_WORDS / BLK_WORDS;
  localparam logic [HI_W-1:0] BUF0_HI = HI_W'(BUF0_BASE / BLK_WORDS);
  localparam logic [HI_W-1:0] BUF1_HI = HI_W'(BUF1_BASE / BLK_WORDS);

  rd_state_t       state;
  logic            mbox_enter, load, last_blk, fall, step, mem_en;
  logic [HI_W-1:0] load_hi, hi_next;

  usbrd_seq #(
    .MBOX_W(MBOX_W), .HI_W(HI_W), .MBOX_CYC(MBOX_CYC),
    .BUF0_HI(BUF0_HI), .BUF1_HI(BUF1_HI)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .mbox_irq_n(mbox_irq_n), .usb_ready(usb_ready),
    .mbox_byte(mbox_rdata), .last_blk(last_blk), .state(state),
    .mbox_enter(mbox_enter), .load(load), .load_hi(load_hi)
  );

  usbrd_fall_detect u_fall (
    .clk(clk), .rst_n(rst_n), .sig(usb_addr[LOW_W-1]), .fall(fall)
  );

  assign step = (state == ST_BURST) && fall;

  usbrd_blk_addr #(.HI_W(HI_W), .XFER_BLKS(XFER_BLKS)) u_blk (
    .clk(clk), .rst_n(rst_n), .load(load), .load_hi(load_hi), .step(step),
    .hi_next(hi_next), .last_blk(last_blk)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 ram_addr <= '0;
    else if (mbox_enter)        ram_addr <= ADDR_W'(MBOX_ADDR);
    else if (load)              ram_addr <= {load_hi, usb_addr};
    else if (state == ST_BURST) ram_addr <= {hi_next, usb_addr};
  end

  assign mem_en   = (state == ST_MBOX) || (state == ST_BURST);
  assign ram_ce_n = ~mem_en;
  assign ram_oe_n = ~mem_en;
  assign ram_wr_n = 1'b1;
  assign usb_irq  = (state != ST_IDLE);

  // R1: the RAM is never touched without a pending request
  assert_req_cover_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !ram_ce_n |-> usb_irq);
  // R2: the RAM opens only after a ready reply, at the mailbox address
  assert_ready_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ram_ce_n && $past(ram_ce_n)) |-> ($past(usb_ready) && ram_addr == ADDR_W'(MBOX_ADDR)));
  // R6: inside a burst the upper bits either hold or advance by one
  assert_hi_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_BURST && $past(state) == ST_BURST) |->
      (ram_addr[ADDR_W-1:LOW_W] == $past(ram_addr[ADDR_W-1:LOW_W]) ||
       ram_addr[ADDR_W-1:LOW_W] == $past(ram_addr[ADDR_W-1:LOW_W]) + HI_W'(1)));
  // R8: the last block boundary closes the transfer
  assert_burst_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_BURST && last_blk) |=> (!usb_irq && ram_ce_n));
endmodule

// File: tb/tb_usb_rd_bridge.sv
module tb_usb_rd_bridge;
  localparam int MBOX_ADDR = 16383;
  localparam int MBOX_CYC  = 2;
  localparam int B0 = 1024 / 512;
  localparam int B1 = 5120 / 512;
  localparam int NBLK = 4096 / 512;

  logic clk = 0, rst_n = 0, mbox_irq_n = 1, usb_ready = 0;
  logic [8:0]  usb_addr = '0;
  logic [7:0]  mbox_val = 8'h00;
  logic [7:0]  mbox_rdata;
  logic [13:0] ram_addr;
  logic usb_irq, ram_ce_n, ram_oe_n, ram_wr_n;
  int n_chk = 0, n_err = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  assign mbox_rdata = (ram_addr == 14'(MBOX_ADDR)) ? mbox_val : (ram_addr[7:0] ^ 8'h5A);

  usb_rd_bridge dut (
    .clk(clk), .rst_n(rst_n), .mbox_irq_n(mbox_irq_n), .usb_irq(usb_irq),
    .usb_ready(usb_ready), .usb_addr(usb_addr), .mbox_rdata(mbox_rdata),
    .ram_addr(ram_addr), .ram_ce_n(ram_ce_n), .ram_oe_n(ram_oe_n), .ram_wr_n(ram_wr_n)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference: phase 0 idle, 1 request, 2 mailbox, 3 burst
  int m_ph = 0, m_cnt = 0, m_blk = 0;
  int m_hi = 0;
  int m_addr = 0;
  bit m_prev8 = 0, m_fall = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_cnt = 0; m_blk = 0; m_hi = 0; m_addr = 0; m_prev8 = 0;
    end else begin
      m_fall  = m_prev8 && !usb_addr[8];
      m_prev8 = usb_addr[8];
      case (m_ph)
        0: if (!mbox_irq_n) m_ph = 1;
        1: if (usb_ready) begin m_ph = 2; m_cnt = 0; m_addr = MBOX_ADDR; end
        2: if (m_cnt == MBOX_CYC - 1) begin
             if (mbox_val == 8'h00 || mbox_val == 8'hFF) begin
               m_hi = (mbox_val == 8'h00) ? B0 : B1;
               m_blk = 0; m_ph = 3;
               m_addr = m_hi * 512 + int'(usb_addr);
             end else m_ph = 0;
           end else m_cnt++;
        default: begin
          if (m_fall) begin m_hi++; m_blk++; end
          m_addr = (m_hi % 32) * 512 + int'(usb_addr);
          if (m_blk == NBLK) m_ph = 0;
        end
      endcase
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk(usb_irq == (m_ph != 0), "R1/R8 usb_irq vs model", usb_irq, m_ph != 0);
      chk(ram_ce_n == (m_ph < 2), "R7 ram_ce_n vs model", ram_ce_n, m_ph < 2);
      chk(ram_oe_n == (m_ph < 2), "R7 ram_oe_n vs model", ram_oe_n, m_ph < 2);
      chk(ram_wr_n == 1'b1, "R7 ram_wr_n", ram_wr_n, 1);
      if (m_ph >= 2) chk(int'(ram_addr) == m_addr, "R5 ram_addr vs model", ram_addr, m_addr);
    end
  end

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic do_xfer(input logic [7:0] code, input int ready_dly, input int base);
    mbox_val = code; mbox_irq_n = 0;
    tick();
    chk(usb_irq == 1, "R1 request raised", usb_irq, 1);
    for (int i = 0; i < ready_dly; i++) begin
      chk(ram_ce_n == 1, "R2 RAM idle before ready", ram_ce_n, 1);
      tick();
    end
    chk(ram_ce_n == 1, "R2 RAM idle before ready", ram_ce_n, 1);
    usb_ready = 1;
    tick();
    chk(ram_ce_n == 0 && ram_addr == 14'(MBOX_ADDR), "R2 mailbox access", ram_addr, MBOX_ADDR);
    usb_ready = 0; mbox_irq_n = 1;
    repeat (MBOX_CYC) tick();
    if (base < 0) begin
      chk(usb_irq == 0, "R4 illegal code drops request", usb_irq, 0);
      chk(ram_ce_n == 1, "R4 illegal code no burst", ram_ce_n, 1);
      repeat (5) tick();
      chk(ram_ce_n == 1 && usb_irq == 0, "R4 stays idle", ram_ce_n, 1);
      return;
    end
    chk(int'(ram_addr[13:9]) == base, "R3 buffer base", ram_addr[13:9], base);
    for (int w = 0; w < 4096; w++) begin
      int hold;
      hold = ((w % 97) == 5) ? 6 : 4;
      usb_addr = 9'(w % 512);
      tick();
      if ((w % 512) == 256)
        chk(int'(ram_addr[13:9]) == base + w / 512, "R6 rising edge no step", ram_addr[13:9], base + w / 512);
      if (w > 0 && (w % 512) == 0)
        chk(int'(ram_addr) == (base + w / 512) * 512, "R6 wrap step", ram_addr, (base + w / 512) * 512);
      repeat (hold - 1) tick();
    end
    usb_addr = 9'd0;
    tick();
    chk(usb_irq == 0 && ram_ce_n == 1, "R8 transfer end", {usb_irq, ram_ce_n}, 1);
    repeat (3) tick();
  endtask

  initial begin
    repeat (4) tick();
    chk(usb_irq == 0 && ram_ce_n == 1 && ram_oe_n == 1, "R1 reset state", {usb_irq, ram_ce_n, ram_oe_n}, 3);
    rst_n = 1;
    repeat (10) tick();
    chk(usb_irq == 0 && ram_ce_n == 1, "R1 idle without interrupt", {usb_irq, ram_ce_n}, 1);
    do_xfer(8'h3C, 2, -1);
    do_xfer(8'h00, 5, B0);
    do_xfer(8'hFF, 0, B1);
    do_xfer(8'hFE, 1, -1);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    finished = 1;
    n_chk++; n_err++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule